// File: doc/BRIEF.md
# Half-Word Parallel Product Array

The block forms the full double-width product of two unsigned multi-word operands. Each operand holds N words of 32 bits and is cut into 2N half-words of 16 bits. A row of 2N multiply-accumulate lanes works through a rotating schedule. In each step, every lane multiplies a different half-word of the first operand by the same half-word of the second operand. The schedule yields 4N-1 partial columns. Each column is the sum of all half-word products of one weight, held 47 bits wide. The upper columns leave the lanes one per step. The lower 2N columns are taken from all lanes in a single cycle.

A folding stage then converts the columns into 2N product words of 32 bits, one word per cycle. Each even column enters its own word whole. Each odd column is split: its low half goes to the current word and its high half to the next word. A narrow running carry links neighbouring words. The block is meant to sit in front of a separate modular reduction unit. A single start pulse launches an operation, and the done level reports that every product word is final.

Top module: `hwm_product_array`

## Requirements
- R1: While reset is applied and after it is released, `done` is 0 and `prod_out` is all zeros.
- R2: A `start` pulse is accepted when no operation is in progress. It captures `a_in` and `b_in`, and `done` is 0 in the cycle after the accepting edge.
- R3: When `done` is high, `prod_out` equals the full unsigned product `a_in * b_in` of the captured operands, exact to 64*N bits.
- R4: `done` rises exactly 4N+1 clock cycles after the edge that accepts `start`. This is 2N schedule steps, one capture cycle and 2N folding cycles.
- R5: While `done` is high and `start` stays low, `done` stays high and `prod_out` stays unchanged, even if `a_in` and `b_in` change.
- R6: A `start` pulse raised while an operation is in progress is ignored. The running operation keeps its operands and its latency.
- R7: Each half-word pair (i of the first operand, j of the second) contributes exactly once, at weight 2^(16*(i+j)). Half-word k occupies bits 16k+15..16k of its operand. This holds both for lanes that pass an upper column on mid-schedule and then start afresh, and for the lanes that do not.
- R8: Column sums above 32 bits carry into the next product word. The carry left after the top word is zero, so all-ones operands give the exact product.
- R9: Word w of an operand is bits 32w+31..32w of its port, and product word w is bits 32w+31..32w of `prod_out`. Word 0 is the least significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch pulse, acted on only when idle |
| a_in | input | 32*N | First operand, word 0 in the low bits |
| b_in | input | 32*N | Second operand, word 0 in the low bits |
| prod_out | output | 64*N | Product, word 0 in the low bits |
| done | output | 1 | High once every product word is final; held until the next accepted start |

## Verification
In every schedule step after the first, one lane hands its finished upper column to storage. In the same cycle, that lane takes in the first product of its next column. A missing clear, or a lost product, would corrupt two columns at once. The bench provokes this collision by sweeping single half-word probes over every position (i, j), together with dense and all-ones patterns, so that lane restarts always carry nonzero products. Each result is judged against a product computed in the bench with plain wide multiplication. A second overlap, a start pulse that arrives mid-operation, is driven on purpose and judged by the result and the unchanged latency.

// File: rtl/hwm_pkg.sv
package hwm_pkg;

    localparam int WORD_W  = 32;
    localparam int HALF_W  = WORD_W / 2;
    localparam int EXT_W   = 47;
    localparam int CARRY_W = EXT_W - WORD_W + 1;

    typedef logic [HALF_W-1:0]  half_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [EXT_W-1:0]   col_t;
    typedef logic [CARRY_W-1:0] carry_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MUL  = 2'd1,
        PH_CAP  = 2'd2,
        PH_FOLD = 2'd3
    } phase_e;

    typedef struct packed {
        word_t  word;
        carry_t carry;
    } fold_out_t;

    // One folding step: even column whole, upper half of the odd column
    // below, lower half of the odd column above shifted up, plus carry.
    function automatic fold_out_t fold_step(
        input col_t   even_c,
        input col_t   below_c,
        input col_t   above_c,
        input carry_t cin,
        input logic   first,
        input logic   last
    );
        col_t      lo_sum;
        col_t      hi_term;
        col_t      total;
        fold_out_t r;
        lo_sum  = even_c + (first ? col_t'(0) : (below_c >> HALF_W));
        hi_term = last ? col_t'(0) : col_t'({above_c[HALF_W-1:0], {HALF_W{1'b0}}});
        hi_term = hi_term | col_t'(cin);
        total   = lo_sum + hi_term;
        r.word  = total[WORD_W-1:0];
        r.carry = carry_t'(total >> WORD_W);
        return r;
    endfunction

endpackage

// File: rtl/hwm_mac_lane.sv
module hwm_mac_lane
    import hwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  run,
    input  logic  restart,
    input  half_t a_h,
    input  half_t b_h,
    output col_t  acc
);

    word_t            prod;
    col_t             acc_q;
    logic [EXT_W:0]   wide_sum;

    assign prod     = word_t'(a_h) * word_t'(b_h);
    assign wide_sum = {1'b0, acc_q} + (EXT_W + 1)'(prod);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
        end else if (run) begin
            if (restart) acc_q <= col_t'(prod);
            else         acc_q <= acc_q + col_t'(prod);
        end
    end

    assign acc = acc_q;

    // R3
    lane_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !restart) |-> !wide_sum[EXT_W]);

endmodule

// File: rtl/hwm_sched.sv
module hwm_sched
    import hwm_pkg::*;
#(
    parameter int LANES = 16,
    localparam int CNT_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output phase_e           phase,
    output logic [CNT_W-1:0] step,
    output logic             accept,
    output logic             done
);

    localparam logic [CNT_W-1:0] LAST_S = CNT_W'(LANES - 1);

    phase_e           phase_q;
    logic [CNT_W-1:0] step_q;
    logic             done_q;

    assign accept = start && (phase_q == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_MUL;
                        step_q  <= '0;
                        done_q  <= 1'b0;
                    end
                end
                PH_MUL: begin
                    if (step_q == LAST_S) begin
                        phase_q <= PH_CAP;
                        step_q  <= '0;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                PH_CAP: begin
                    phase_q <= PH_FOLD;
                    step_q  <= '0;
                end
                default: begin
                    if (step_q == LAST_S) begin
                        phase_q <= PH_IDLE;
                        step_q  <= '0;
                        done_q  <= 1'b1;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign phase = phase_q;
    assign step  = step_q;
    assign done  = done_q;

    // R4
    mul_step_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_MUL && step_q != LAST_S) |=>
            (phase_q == PH_MUL && step_q == CNT_W'($past(step_q) + 1'b1)));

    // R4
    fold_end_done_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FOLD && step_q == LAST_S) |=> done_q);

endmodule

// File: rtl/hwm_col_bank.sv
module hwm_col_bank
    import hwm_pkg::*;
#(
    parameter int LANES = 16,
    localparam int CNT_W = $clog2(LANES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  phase_e                 phase,
    input  logic [CNT_W-1:0]       step,
    input  col_t [LANES-1:0]       acc,
    output col_t [2*LANES-1:0]     cols
);

    // Columns 0..LANES-1 are taken in the capture cycle from lane LANES-1-k.
    // Columns LANES..2*LANES-2 leave lane 2*LANES-1-k during the schedule.
    // The top entry is a constant zero so the fold stage can index it freely.
    for (genvar k = 0; k < 2 * LANES; k++) begin : g_col
        if (k == 2 * LANES - 1) begin : g_zero
            assign cols[k] = '0;
        end else if (k < LANES) begin : g_low
            col_t col_q;
            always_ff @(posedge clk) begin
                if (rst)                  col_q <= '0;
                else if (phase == PH_CAP) col_q <= acc[LANES-1-k];
            end
            assign cols[k] = col_q;
        end else begin : g_high
            localparam int SRC = 2 * LANES - 1 - k;
            col_t col_q;
            always_ff @(posedge clk) begin
                if (rst)
                    col_q <= '0;
                else if (phase == PH_MUL && step == CNT_W'(SRC))
                    col_q <= acc[SRC];
            end
            assign cols[k] = col_q;
        end
    end

endmodule

// File: rtl/hwm_fold.sv
module hwm_fold
    import hwm_pkg::*;
#(
    parameter int LANES = 16,
    localparam int CNT_W = $clog2(LANES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  phase_e                 phase,
    input  logic [CNT_W-1:0]       step,
    input  col_t [2*LANES-1:0]     cols,
    output word_t [LANES-1:0]      prod
);

    localparam logic [CNT_W-1:0] LAST_S = CNT_W'(LANES - 1);

    logic [CNT_W:0]   even_idx;
    logic             first;
    logic             last;
    col_t             even_c;
    col_t             below_c;
    col_t             above_c;
    carry_t           carry_q;
    fold_out_t        fo;
    word_t [LANES-1:0] prod_q;

    assign even_idx = {step, 1'b0};
    assign first    = (step == '0);
    assign last     = (step == LAST_S);

    always_comb begin
        even_c  = cols[even_idx];
        below_c = first ? col_t'(0) : cols[even_idx - 1'b1];
        above_c = cols[even_idx + 1'b1];
        fo      = fold_step(even_c, below_c, above_c, carry_q, first, last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= '0;
            prod_q  <= '0;
        end else if (phase == PH_CAP) begin
            carry_q <= '0;
        end else if (phase == PH_FOLD) begin
            prod_q[step] <= fo.word;
            carry_q      <= fo.carry;
        end
    end

    assign prod = prod_q;

    // R8
    top_carry_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FOLD && last) |-> (fo.carry == '0));

endmodule

// File: rtl/hwm_product_array.sv
module hwm_product_array
    import hwm_pkg::*;
#(
    parameter int N = 8,
    localparam int LANES = 2 * N,
    localparam int CNT_W = $clog2(LANES),
    localparam int OP_W  = N * WORD_W,
    localparam int PR_W  = 2 * OP_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [OP_W-1:0] a_in,
    input  logic [OP_W-1:0] b_in,
    output logic [PR_W-1:0] prod_out,
    output logic            done
);

    localparam logic [CNT_W:0] LANES_V = (CNT_W + 1)'(LANES);

    phase_e             phase;
    logic [CNT_W-1:0]   step;
    logic               accept;
    logic [OP_W-1:0]    a_q;
    logic [OP_W-1:0]    b_q;
    logic [CNT_W-1:0]   b_idx;
    half_t              b_h;
    col_t [LANES-1:0]   acc;
    col_t [2*LANES-1:0] cols;
    word_t [LANES-1:0]  prod_w;
    logic               run;

    hwm_sched #(.LANES(LANES)) u_sched (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .phase  (phase),
        .step   (step),
        .accept (accept),
        .done   (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (accept) begin
            a_q <= a_in;
            b_q <= b_in;
        end
    end

    assign run   = (phase == PH_MUL);
    assign b_idx = CNT_W'(LANES - 1) - step;
    assign b_h   = b_q[b_idx*HALF_W +: HALF_W];

    // Lane x takes half-word (step - x) mod LANES of the first operand.
    for (genvar x = 0; x < LANES; x++) begin : g_lane
        localparam logic [CNT_W:0] OFF = (CNT_W + 1)'(LANES - x);
        logic [CNT_W:0]   raw;
        logic [CNT_W-1:0] a_idx;
        half_t            a_h;
        logic             restart;

        assign raw     = {1'b0, step} + OFF;
        assign a_idx   = (raw >= LANES_V) ? CNT_W'(raw - LANES_V) : CNT_W'(raw);
        assign a_h     = a_q[a_idx*HALF_W +: HALF_W];
        assign restart = (x != 0) && (step == CNT_W'(x));

        hwm_mac_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .clr     (accept),
            .run     (run),
            .restart (restart),
            .a_h     (a_h),
            .b_h     (b_h),
            .acc     (acc[x])
        );
    end

    hwm_col_bank #(.LANES(LANES)) u_cols (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .step  (step),
        .acc   (acc),
        .cols  (cols)
    );

    hwm_fold #(.LANES(LANES)) u_fold (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .step  (step),
        .cols  (cols),
        .prod  (prod_w)
    );

    assign prod_out = prod_w;

    // R2
    start_drops_done_chk: assert property (@(posedge clk) disable iff (rst)
        (start && done) |=> !done);

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(prod_out)));

    // R6
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (start && phase != PH_IDLE) |=> ($stable(a_q) && $stable(b_q)));

endmodule

// File: tb/test_hwm_product_array.sv
module test_hwm_product_array;

    localparam int N     = 2;
    localparam int OPW   = N * 32;
    localparam int PW    = 2 * OPW;
    localparam int LAT   = 4 * N + 1;
    localparam time CLK_P = 20ns;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [OPW-1:0] a_in = '0;
    logic [OPW-1:0] b_in = '0;
    logic [PW-1:0]  prod_out;
    logic           done;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_P / 2) clk = ~clk;

    hwm_product_array #(.N(N)) i_hwm_product_array (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .a_in     (a_in),
        .b_in     (b_in),
        .prod_out (prod_out),
        .done     (done)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] ref_mul(input logic [OPW-1:0] a,
                                             input logic [OPW-1:0] b);
        return {{OPW{1'b0}}, a} * {{OPW{1'b0}}, b};
    endfunction

    function automatic logic [15:0] hv(input int i);
        case (i % 6)
            0:       return 16'h0000;
            1:       return 16'h0001;
            2:       return 16'h7fff;
            3:       return 16'h8000;
            4:       return 16'hffff;
            default: return 16'h5a3c;
        endcase
    endfunction

    // Runs one operation; optionally pulses start again while busy.
    task automatic run_op(input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                          input string req, input bit poke,
                          input logic [OPW-1:0] a2, input logic [OPW-1:0] b2);
        int n;
        @(negedge clk);
        a_in  = a;
        b_in  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: done low right after the accepting edge
        chk(done == 1'b0, "R2 done cleared", PW'(done), '0);
        n = 0;
        while (!done && n < 1000) begin
            if (poke && n == 2) begin
                a_in  = a2;
                b_in  = b2;
                start = 1'b1;
            end else begin
                start = 1'b0;
                a_in  = ~a;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        // R4: latency from the accepting edge
        chk(n == LAT, poke ? "R6 latency kept" : "R4 latency", PW'(n), PW'(LAT));
        chk(prod_out == ref_mul(a, b), req, prod_out, ref_mul(a, b));
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [PW-1:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state while reset held
        chk(done == 1'b0 && prod_out == '0, "R1 reset", prod_out, '0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && prod_out == '0, "R1 after release", prod_out, '0);

        // R9: word order, 1*1 lands in low bits of word 0
        run_op(64'd1, 64'd1, "R9 unit product", 1'b0, '0, '0);
        chk(prod_out[31:0] == 32'd1, "R9 word0 position", PW'(prod_out[31:0]), PW'(1));
        run_op(64'h1_0000_0000, 64'h1_0000_0000, "R9 word2 product", 1'b0, '0, '0);
        chk(prod_out[95:64] == 32'd1, "R9 word2 position", PW'(prod_out[95:64]), PW'(1));

        // R7: every half-word pair position, single probes
        for (int i = 0; i < 2 * N; i++) begin
            for (int j = 0; j < 2 * N; j++) begin
                run_op(OPW'(64'hffff) << (16 * i), OPW'(64'hffff) << (16 * j),
                       "R7 half-word pair", 1'b0, '0, '0);
            end
        end

        // R8: all ones and carry chains
        run_op('1, '1, "R8 all ones", 1'b0, '0, '0);
        run_op('1, 64'd1, "R8 ones by one", 1'b0, '0, '0);
        run_op({OPW{1'b0}}, '1, "R3 zero operand", 1'b0, '0, '0);

        // R3: structured sweep over corner half-word values
        for (int ia = 0; ia < 6; ia++) begin
            for (int ib = 0; ib < 6; ib++) begin
                run_op({hv(ia), hv(ib), hv(ia + 1), hv(ib + 2)},
                       {hv(ia + 3), hv(ib), hv(ia * ib), hv(ia + ib)},
                       "R3 corner sweep", 1'b0, '0, '0);
            end
        end

        // R3: random operands
        for (int r = 0; r < 40; r++) begin
            run_op({$urandom, $urandom}, {$urandom, $urandom}, "R3 random", 1'b0, '0, '0);
        end

        // R5: result held with inputs changing and no start
        held = prod_out;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            a_in = {$urandom, $urandom};
            b_in = {$urandom, $urandom};
        end
        chk(done == 1'b1 && prod_out == held, "R5 hold", prod_out, held);

        // R6: start while busy ignored
        run_op(64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210, "R6 busy start result",
               1'b1, '1, '1);
        run_op('1, 64'h8000_0000_0000_0001, "R6 busy start result 2",
               1'b1, 64'd3, 64'd5);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule